// File: doc/BRIEF.md
# Root Port PME Status Controller

This block holds the root-control and root-status registers of a PCIe-style root port. It records power-management event (PME) messages, each arriving with a 16-bit requestor ID. The first event sets a status flag and latches its ID. A second event that arrives before software acknowledges the first is parked in a single pending slot. It is promoted automatically when software clears the status flag with a write-one-to-clear. A level interrupt follows the status flag when software has enabled it.

The same control register also gates error reporting. Fatal, non-fatal and correctable error reports can come from the root port itself or from the hierarchy below it. Each report becomes a one-cycle system-error pulse, but only when the enable for its class and the command-register system-error enable are both set.

Software reads both registers continuously and writes them through single-cycle write strobes. A sticky debug output flags any event that was dropped because both the status and pending slots were occupied.

Top module: `pme_root_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control read value, the status read value, `pme_irq`, `serr_pulse` and `pme_overflow` are all zero.
- R2: A control write stores data bits 3:0: bit 3 interrupt enable, bit 2 fatal enable, bit 1 non-fatal enable, bit 0 correctable enable. Control read bits 15:4 are always zero.
- R3: A PME arriving while status (status bit 16) is clear sets status and loads its requestor ID into status bits 15:0, visible the cycle after the event.
- R4: A PME arriving while status is set and nothing is pending leaves bits 15:0 unchanged and sets pending (status bit 17).
- R5: A status write with bit 16 at 1 clears status when nothing is pending. When an event is pending, the same write keeps status set, loads the pending ID into bits 15:0 and clears pending. A status write with bit 16 at 0 changes nothing.
- R6: When a clearing status write and a PME occur in the same cycle, the new PME wins. With nothing pending, status stays set and bits 15:0 take the new ID. With an event pending, the pending ID moves to bits 15:0 and the new PME becomes pending.
- R7: A PME arriving while status and pending are both set is dropped without changing the status value, and `pme_overflow` becomes 1 and stays 1 until reset.
- R8: `pme_irq` equals the interrupt enable ANDed with status. It therefore rises when status sets with the enable on, or when the enable is written while status is already set.
- R9: `serr_pulse` is 1 in the cycle after an error report exactly when some reported class has its enable set and `cmd_serr_en` is 1. A single-cycle report gives a single-cycle pulse.
- R10: Writes to status bits 31:17 and 15:0 have no effect, and status bits 31:18 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write data |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status register write data (bit 16 is write-one-to-clear) |
| ctl_rdata | output | 16 | Control register read value |
| sts_rdata | output | 32 | Status register read value |
| pme_valid | input | 1 | One-cycle PME message strobe |
| pme_rid | input | 16 | Requestor ID of the PME message |
| err_fatal | input | 1 | Fatal error report |
| err_nonfatal | input | 1 | Non-fatal error report |
| err_corr | input | 1 | Correctable error report |
| cmd_serr_en | input | 1 | Command-register system-error enable |
| pme_irq | output | 1 | Level PME interrupt |
| serr_pulse | output | 1 | One-cycle system-error pulse |
| pme_overflow | output | 1 | Sticky debug flag for a dropped PME |

## Verification
The embedded assertions check several rules on every cycle: pending never exists without status, the captured ID holds while later events queue, a first event is captured, a pending ID is promoted on acknowledge, overflow is sticky, the interrupt never fires without status, and a system-error pulse never occurs without the command enable. Only the bench's scenarios can show the rest. That covers the exact ordering of IDs across long runs of events and clears, the same-cycle clear-and-event race in both pending states, the masking of read-only and reserved bits, and per-class error gating. The bench tests these against a reference model under mixed random and directed traffic.

// File: rtl/pme_root_pkg.sv
// Package: shared widths, bit positions and the control field type for the
// root port PME status controller. Assumes 16-bit control, 32-bit status.
package pme_root_pkg;
    parameter int CTL_W   = 16;
    parameter int STS_W   = 32;
    parameter int RID_W   = 16;
    parameter int ERR_CLS = 3;

    localparam int STS_BIT  = RID_W;      // status flag position
    localparam int PEND_BIT = RID_W + 1;  // pending flag position
    localparam int CTL_USED = ERR_CLS + 1;

    typedef struct packed {
        logic irq_en;     // bit 3
        logic fatal_en;   // bit 2
        logic nonfat_en;  // bit 1
        logic corr_en;    // bit 0
    } root_ctl_t;
endpackage

// File: rtl/pme_event_tracker.sv
// Module: holds PME status, the captured requestor ID, one pending event and
// a sticky overflow flag. Assumes evt_valid is a one-cycle strobe and ack is
// the decoded write-one-to-clear of the status flag.
module pme_event_tracker #(
    parameter int RID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [RID_W-1:0] evt_rid,
    input  logic             ack,
    output logic             sts_q,
    output logic             pend_q,
    output logic [RID_W-1:0] rid_q,
    output logic             ovf_q
);
    logic [RID_W-1:0] pend_rid_q;
    logic             ack_eff;

    // An acknowledge only acts while status is set.
    assign ack_eff = ack && sts_q;

    // Status, capture, pending slot and overflow update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q      <= 1'b0;
            pend_q     <= 1'b0;
            rid_q      <= '0;
            pend_rid_q <= '0;
            ovf_q      <= 1'b0;
        end else if (evt_valid && ack_eff) begin
            if (pend_q) begin
                rid_q      <= pend_rid_q;
                pend_rid_q <= evt_rid;
            end else begin
                rid_q <= evt_rid;
            end
        end else if (evt_valid) begin
            if (!sts_q) begin
                sts_q <= 1'b1;
                rid_q <= evt_rid;
            end else if (!pend_q) begin
                pend_q     <= 1'b1;
                pend_rid_q <= evt_rid;
            end else begin
                ovf_q <= 1'b1;
            end
        end else if (ack_eff) begin
            if (pend_q) begin
                rid_q  <= pend_rid_q;
                pend_q <= 1'b0;
            end else begin
                sts_q <= 1'b0;
            end
        end
    end

    assert_pend_needs_sts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> sts_q);
    assert_rid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && evt_valid && !ack_eff) |=> $stable(rid_q));
    assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_q && evt_valid) |=> (sts_q && rid_q == $past(evt_rid)));
    assert_promote_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_eff && pend_q && !evt_valid) |=> (sts_q && !pend_q && rid_q == $past(pend_rid_q)));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
endmodule

// File: rtl/err_serr_gen.sv
// Module: turns per-class error reports into a registered one-cycle
// system-error pulse. Assumes reports are sampled each cycle, and that a class
// counts only when both its own enable and the command enable are set.
module err_serr_gen #(
    parameter int NCLS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] err,
    input  logic [NCLS-1:0] cls_en,
    input  logic            cmd_en,
    output logic            serr_q
);
    logic [NCLS-1:0] qual;

    // Per-class qualification.
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        assign qual[g] = err[g] & cls_en[g];
    end

    // Register the combined pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_q <= 1'b0;
        else        serr_q <= cmd_en && (|qual);
    end

    assert_serr_cmd_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_q |-> $past(cmd_en));
    assert_serr_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_q |-> ($past(err) != '0));
endmodule

// File: rtl/pme_root_ctrl.sv
// Module: top of the root port PME status controller. Holds the control
// register, decodes the status write-one-to-clear, assembles read values and
// drives the interrupt. Assumes single-cycle write strobes.
module pme_root_ctrl
    import pme_root_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    input  logic        sts_wr,
    input  logic [31:0] sts_wdata,
    output logic [15:0] ctl_rdata,
    output logic [31:0] sts_rdata,
    input  logic        pme_valid,
    input  logic [15:0] pme_rid,
    input  logic        err_fatal,
    input  logic        err_nonfatal,
    input  logic        err_corr,
    input  logic        cmd_serr_en,
    output logic        pme_irq,
    output logic        serr_pulse,
    output logic        pme_overflow
);
    root_ctl_t        ctl_q;
    logic             sts_flag;
    logic             pend_flag;
    logic [RID_W-1:0] cap_rid;
    logic             ack;

    // Control register: only the defined low bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= root_ctl_t'(ctl_wdata[CTL_USED-1:0]);
    end

    // Write-one-to-clear decode of the status flag.
    assign ack = sts_wr && sts_wdata[STS_BIT];

    pme_event_tracker #(.RID_W(RID_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(pme_valid),
        .evt_rid  (pme_rid),
        .ack      (ack),
        .sts_q    (sts_flag),
        .pend_q   (pend_flag),
        .rid_q    (cap_rid),
        .ovf_q    (pme_overflow)
    );

    err_serr_gen #(.NCLS(ERR_CLS)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .err   ({err_fatal, err_nonfatal, err_corr}),
        .cls_en({ctl_q.fatal_en, ctl_q.nonfat_en, ctl_q.corr_en}),
        .cmd_en(cmd_serr_en),
        .serr_q(serr_pulse)
    );

    // Read values with reserved bits forced to zero.
    assign ctl_rdata = {{(CTL_W-CTL_USED){1'b0}}, ctl_q};
    assign sts_rdata = {{(STS_W-RID_W-2){1'b0}}, pend_flag, sts_flag, cap_rid};

    // Level interrupt.
    assign pme_irq = ctl_q.irq_en && sts_flag;

    assert_irq_needs_sts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pme_irq |-> sts_rdata[STS_BIT]);
    assert_ctl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_W-1:CTL_USED] == '0);
endmodule

// File: tb/sim_pme_root_ctrl.sv
`timescale 1ns/1ps
module sim_pme_root_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic [15:0] ctl_rdata;
    logic [31:0] sts_rdata;
    logic        pme_valid = 1'b0;
    logic [15:0] pme_rid = '0;
    logic        err_fatal = 1'b0, err_nonfatal = 1'b0, err_corr = 1'b0;
    logic        cmd_serr_en = 1'b0;
    logic        pme_irq, serr_pulse, pme_overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic        m_sts, m_pend, m_ovf;
    logic [15:0] m_rid, m_pid;
    logic [3:0]  m_ctl;
    logic        m_serr;

    always #2.5 clk = ~clk;

    pme_root_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ctl_rdata(ctl_rdata),
        .sts_rdata(sts_rdata), .pme_valid(pme_valid), .pme_rid(pme_rid),
        .err_fatal(err_fatal), .err_nonfatal(err_nonfatal), .err_corr(err_corr),
        .cmd_serr_en(cmd_serr_en), .pme_irq(pme_irq), .serr_pulse(serr_pulse),
        .pme_overflow(pme_overflow)
    );

    function automatic logic [31:0] exp_sts();
        return {14'b0, m_pend, m_sts, m_rid};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle, advance the model, compare all outputs.
    task automatic apply(input logic cw, input logic [15:0] cd, input logic sw,
                         input logic [31:0] sd, input logic pv, input logic [15:0] pid,
                         input logic [2:0] errs, input logic cmd);
        logic clr;
        @(negedge clk);
        ctl_wr = cw; ctl_wdata = cd; sts_wr = sw; sts_wdata = sd;
        pme_valid = pv; pme_rid = pid;
        {err_fatal, err_nonfatal, err_corr} = errs; cmd_serr_en = cmd;
        m_serr = cmd && ((errs & m_ctl[2:0]) != 3'b0);
        clr = sw && sd[16] && m_sts;
        if (pv && clr) begin
            if (m_pend) begin m_rid = m_pid; m_pid = pid; end
            else m_rid = pid;
        end else if (pv) begin
            if (!m_sts) begin m_sts = 1; m_rid = pid; end
            else if (!m_pend) begin m_pend = 1; m_pid = pid; end
            else m_ovf = 1;
        end else if (clr) begin
            if (m_pend) begin m_rid = m_pid; m_pend = 0; end
            else m_sts = 0;
        end
        if (cw) m_ctl = cd[3:0];
        @(posedge clk);
        #1;
        check("R3/R4/R5/R6 status model", sts_rdata, exp_sts());
        check("R2 control model", {16'b0, ctl_rdata}, {28'b0, m_ctl});
        check("R8 irq model", {31'b0, pme_irq}, {31'b0, m_ctl[3] & m_sts});
        check("R9 serr model", {31'b0, serr_pulse}, {31'b0, m_serr});
        check("R7 overflow model", {31'b0, pme_overflow}, {31'b0, m_ovf});
    endtask

    task automatic idle();
        apply(0, 0, 0, 0, 0, 0, 3'b0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7781));
        m_sts = 0; m_pend = 0; m_ovf = 0; m_rid = 0; m_pid = 0; m_ctl = 0; m_serr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        // R1 reset state
        check("R1 ctl reset", {16'b0, ctl_rdata}, 32'h0);
        check("R1 sts reset", sts_rdata, 32'h0);
        check("R1 outputs reset", {29'b0, pme_irq, serr_pulse, pme_overflow}, 32'h0);

        // R2 control write, reserved bits read zero
        apply(1, 16'hFFFF, 0, 0, 0, 0, 3'b0, 0);
        check("R2 ctl stores low bits", {16'b0, ctl_rdata}, 32'h0000_000F);
        apply(1, 16'h0000, 0, 0, 0, 0, 3'b0, 0);

        // R3 first PME
        apply(0, 0, 0, 0, 1, 16'h1234, 3'b0, 0);
        check("R3 first capture", sts_rdata, 32'h0001_1234);
        check("R8 irq off when disabled", {31'b0, pme_irq}, 32'h0);
        // R8 enable while status set
        apply(1, 16'h0008, 0, 0, 0, 0, 3'b0, 0);
        check("R8 irq on enable", {31'b0, pme_irq}, 32'h1);
        // R4 second PME pends
        apply(0, 0, 0, 0, 1, 16'hABCD, 3'b0, 0);
        check("R4 pending set id held", sts_rdata, 32'h0003_1234);
        // R7 third PME dropped
        apply(0, 0, 0, 0, 1, 16'h5555, 3'b0, 0);
        check("R7 drop keeps status", sts_rdata, 32'h0003_1234);
        check("R7 overflow set", {31'b0, pme_overflow}, 32'h1);
        // R10 write with bit16 zero changes nothing
        apply(0, 0, 1, 32'hFFFE_FFFF, 0, 0, 3'b0, 0);
        check("R10 ro bits ignored", sts_rdata, 32'h0003_1234);
        // R5 clear with pending promotes
        apply(0, 0, 1, 32'h0001_0000, 0, 0, 3'b0, 0);
        check("R5 promote pending", sts_rdata, 32'h0001_ABCD);
        apply(0, 0, 1, 32'h0001_0000, 0, 0, 3'b0, 0);
        check("R5 clear status", sts_rdata, 32'h0000_ABCD);
        check("R8 irq drops", {31'b0, pme_irq}, 32'h0);
        check("R7 overflow sticky", {31'b0, pme_overflow}, 32'h1);
        // R6 race without pending
        apply(0, 0, 0, 0, 1, 16'h1111, 3'b0, 0);
        apply(0, 0, 1, 32'h0001_0000, 1, 16'h2222, 3'b0, 0);
        check("R6 race no pending", sts_rdata, 32'h0001_2222);
        // R6 race with pending
        apply(0, 0, 0, 0, 1, 16'h3333, 3'b0, 0);
        apply(0, 0, 1, 32'h0001_0000, 1, 16'h4444, 3'b0, 0);
        check("R6 race with pending", sts_rdata, 32'h0003_3333);
        apply(0, 0, 1, 32'h0001_0000, 0, 0, 3'b0, 0);
        check("R6 new event promoted", sts_rdata, 32'h0001_4444);
        apply(0, 0, 1, 32'h0001_0000, 0, 0, 3'b0, 0);

        // R9 error gating
        apply(1, 16'h0004, 0, 0, 0, 0, 3'b0, 0);
        apply(0, 0, 0, 0, 0, 0, 3'b100, 1);
        check("R9 fatal pulse", {31'b0, serr_pulse}, 32'h1);
        idle();
        check("R9 pulse one cycle", {31'b0, serr_pulse}, 32'h0);
        apply(0, 0, 0, 0, 0, 0, 3'b010, 1);
        check("R9 nonfatal masked", {31'b0, serr_pulse}, 32'h0);
        apply(0, 0, 0, 0, 0, 0, 3'b100, 0);
        check("R9 cmd enable off", {31'b0, serr_pulse}, 32'h0);

        // random mixed traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic cw, sw, pv, cmd;
            logic [15:0] cd, pid;
            logic [31:0] sd;
            logic [2:0] errs;
            cw   = ($urandom % 10) == 0;
            cd   = 16'($urandom);
            sw   = ($urandom % 3) == 0;
            sd   = $urandom;
            pv   = ($urandom % 3) == 0;
            pid  = 16'($urandom);
            errs = 3'($urandom);
            cmd  = ($urandom % 4) != 0;
            apply(cw, cd, sw, sd, pv, pid, errs, cmd);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule